// File: doc/BRIEF.md
# Two-Source Interrupt Level Responder

This block sits inside a peripheral that holds two serial engines, a queued SPI engine and a UART. It turns their service requests into the CPU's prioritised interrupt scheme. Software gives each engine a 3-bit priority level. While an engine requests service at a nonzero level, the block pulls the active-low request line for that level. When the CPU runs an interrupt-acknowledge cycle, it presents the level being acknowledged. The block answers with a one-cycle vector strobe only if one of its requesting engines owns that level.

The vector byte combines two parts. The upper bits come from a software-written vector register. The lowest bit names the engine being served. When both engines request at the same level, the SPI engine wins. A fixed, nonzero arbitration identity is presented so that bus-level logic outside this block can separate this peripheral from others that request at the same level.

Top module: `irq_responder`

## Requirements
- R1: After reset, every line of `irq_n` is high, `vec_valid` is low, `vec_out` is zero, both levels are 0 and the vector register holds 0x0F.
- R2: A write with `cfg_addr`=0 loads the SPI level from `cfg_wdata[2:0]` and the UART level from `cfg_wdata[6:4]`. A write with `cfg_addr`=1 loads the whole vector register from `cfg_wdata[7:0]`.
- R3: When an engine requests with level L (1..7), `irq_n[L]` is low one clock after the request and level are sampled. The line returns high one clock after the request drops.
- R4: An engine whose level is 0 drives no request line and is never answered in an acknowledge.
- R5: When both engines request at different nonzero levels, both matching lines are low at the same time. No other line is low.
- R6: An `iack_valid` cycle whose `iack_level` equals the level of a requesting engine produces `vec_valid` high for exactly the next clock. In that clock, `vec_out` = {vector[7:1], id}, where id is 1 for the SPI engine and 0 for the UART. `vec_out` is zero whenever `vec_valid` is low.
- R7: An acknowledge at a level that no requesting engine owns produces no strobe. This includes level 0.
- R8: When both engines request at the same nonzero level and that level is acknowledged, the SPI engine is served, so `vec_out[0]`=1.
- R9: The vector bits above bit 0 come from the vector register as it stood in the acknowledge cycle. With the reset value this gives 0x0F for the SPI engine and 0x0E for the UART.
- R10: `arb_id` always equals the nonzero parameter `ARB_ID` (default 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 levels, 1 vector |
| cfg_wdata | input | 8 | Write data |
| spi_req | input | 1 | SPI engine service request (level held) |
| uart_req | input | 1 | UART service request (level held) |
| iack_valid | input | 1 | Interrupt-acknowledge cycle present |
| iack_level | input | 3 | Level being acknowledged by the CPU |
| irq_n | output | 7 ([7:1]) | Active-low request lines, index equals level |
| vec_valid | output | 1 | One-cycle acknowledge response strobe |
| vec_out | output | 8 | Vector byte returned with the strobe |
| arb_id | output | 4 | Fixed arbitration identity |

## Verification
On every clock, the assertions check the following: the line that a requesting engine's level selects, that level 0 stays silent, that no more than two lines are active, that a matched acknowledge is strobed with the right source bit, that the SPI engine wins ties, that unmatched acknowledges stay quiet, and that the vector bits track the register. Some behaviours can only be shown by the bench's scenarios: the reset value of the vector, the field positions of register writes, the exact byte returned after a software vector change, and the constant arbitration identity.

// File: rtl/irq_resp_pkg.sv
// Shared definitions for the two-source interrupt responder.
// Assumes: register select is a single bit, source identity is one bit.
package irq_resp_pkg;
    // Identity carried in the vector's low bit
    typedef enum logic {
        SRC_UART = 1'b0,
        SRC_SPI  = 1'b1
    } src_id_e;

    // Register select values on the configuration bus
    localparam logic SEL_LEVELS = 1'b0;
    localparam logic SEL_VECTOR = 1'b1;
endpackage

// File: rtl/irq_cfg_regs.sv
// Configuration storage: one level per engine and the vector register.
// Assumes: DATA_W holds both level fields (SPI in the low half, UART in
// the upper half) and equals the vector width.
module irq_cfg_regs
    import irq_resp_pkg::*;
#(
    parameter int              LVL_W   = 3,
    parameter int              DATA_W  = 8,
    parameter logic [DATA_W-1:0] VEC_RST = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [LVL_W-1:0]  spi_lvl,
    output logic [LVL_W-1:0]  uart_lvl,
    output logic [DATA_W-1:0] vec_reg
);
    localparam int UART_LSB = DATA_W / 2;

    // Level fields: cleared by reset, loaded on a level-register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spi_lvl  <= '0;
            uart_lvl <= '0;
        end else if (wr_en && wr_sel == SEL_LEVELS) begin
            spi_lvl  <= wr_data[LVL_W-1:0];
            uart_lvl <= wr_data[UART_LSB+LVL_W-1:UART_LSB];
        end
    end

    // Vector register: reset to the uninitialised vector, loaded on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_reg <= VEC_RST;
        end else if (wr_en && wr_sel == SEL_VECTOR) begin
            vec_reg <= wr_data;
        end
    end
endmodule

// File: rtl/irq_line_encoder.sv
// Decodes each engine's level into the active-low request line bank.
// Assumes: line k (1..2**LVL_W-1) belongs to level k; level 0 drives none.
module irq_line_encoder #(
    parameter int LVL_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     spi_req,
    input  logic                     uart_req,
    input  logic [LVL_W-1:0]         spi_lvl,
    input  logic [LVL_W-1:0]         uart_lvl,
    output logic [(2**LVL_W)-1:1]    irq_n
);
    localparam int NUM_LINES = (2**LVL_W) - 1;

    for (genvar k = 1; k <= NUM_LINES; k++) begin : g_line
        logic want;

        // Line k is wanted when a requesting engine is programmed to level k
        always_comb begin
            want = (spi_req  && (spi_lvl  == LVL_W'(k))) ||
                   (uart_req && (uart_lvl == LVL_W'(k)));
        end

        // Register the line so the CPU sees a glitch-free level
        always_ff @(posedge clk) begin
            if (!rst_n) irq_n[k] <= 1'b1;
            else        irq_n[k] <= ~want;
        end
    end
endmodule

// File: rtl/irq_ack_matcher.sv
// Answers acknowledge cycles: matches the acknowledged level against each
// requesting engine, breaks ties toward SPI, and strobes the vector byte.
// Assumes: acknowledge inputs are valid in the cycle iack_valid is high.
module irq_ack_matcher
    import irq_resp_pkg::*;
#(
    parameter int LVL_W = 3,
    parameter int VEC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_req,
    input  logic              uart_req,
    input  logic [LVL_W-1:0]  spi_lvl,
    input  logic [LVL_W-1:0]  uart_lvl,
    input  logic [VEC_W-1:0]  vec_reg,
    input  logic              iack_valid,
    input  logic [LVL_W-1:0]  iack_level,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_out
);
    logic    spi_hit;
    logic    uart_hit;
    logic    any_hit;
    src_id_e winner;

    // Per-engine match: active request, nonzero level, level acknowledged
    always_comb begin
        spi_hit  = iack_valid && spi_req  && (spi_lvl  != '0) && (spi_lvl  == iack_level);
        uart_hit = iack_valid && uart_req && (uart_lvl != '0) && (uart_lvl == iack_level);
        any_hit  = spi_hit || uart_hit;
    end

    // Fixed tie-break: SPI beats UART at a shared level
    always_comb begin
        winner = spi_hit ? SRC_SPI : SRC_UART;
    end

    // Response register: one-cycle strobe with the assembled vector byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else if (any_hit) begin
            vec_valid <= 1'b1;
            vec_out   <= {vec_reg[VEC_W-1:1], winner};
        end else begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end
    end
endmodule

// File: rtl/irq_responder.sv
// Top of the two-source interrupt responder. Ties configuration storage,
// the request-line encoder and the acknowledge matcher together, and
// presents the fixed arbitration identity.
// Assumes: ARB_ID is nonzero; DATA_W equals VEC_W.
module irq_responder #(
    parameter int               LVL_W   = 3,
    parameter int               VEC_W   = 8,
    parameter int               ARB_W   = 4,
    parameter logic [ARB_W-1:0] ARB_ID  = 4'd3,
    parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic                   cfg_addr,
    input  logic [VEC_W-1:0]       cfg_wdata,
    input  logic                   spi_req,
    input  logic                   uart_req,
    input  logic                   iack_valid,
    input  logic [LVL_W-1:0]       iack_level,
    output logic [(2**LVL_W)-1:1]  irq_n,
    output logic                   vec_valid,
    output logic [VEC_W-1:0]       vec_out,
    output logic [ARB_W-1:0]       arb_id
);
    logic [LVL_W-1:0] spi_lvl;
    logic [LVL_W-1:0] uart_lvl;
    logic [VEC_W-1:0] vec_reg;

    if (ARB_ID == '0) begin : g_bad_arb
        $error("ARB_ID must be nonzero");
    end

    irq_cfg_regs #(
        .LVL_W   (LVL_W),
        .DATA_W  (VEC_W),
        .VEC_RST (VEC_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_sel   (cfg_addr),
        .wr_data  (cfg_wdata),
        .spi_lvl  (spi_lvl),
        .uart_lvl (uart_lvl),
        .vec_reg  (vec_reg)
    );

    irq_line_encoder #(
        .LVL_W (LVL_W)
    ) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_req  (spi_req),
        .uart_req (uart_req),
        .spi_lvl  (spi_lvl),
        .uart_lvl (uart_lvl),
        .irq_n    (irq_n)
    );

    irq_ack_matcher #(
        .LVL_W (LVL_W),
        .VEC_W (VEC_W)
    ) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_req    (spi_req),
        .uart_req   (uart_req),
        .spi_lvl    (spi_lvl),
        .uart_lvl   (uart_lvl),
        .vec_reg    (vec_reg),
        .iack_valid (iack_valid),
        .iack_level (iack_level),
        .vec_valid  (vec_valid),
        .vec_out    (vec_out)
    );

    // Arbitration identity is a fixed strap
    always_comb arb_id = ARB_ID;
endmodule

// File: rtl/irq_responder_chk.sv
// Cycle-by-cycle properties of the responder, bound onto its top module.
// Assumes: observes the internal level and vector registers through bind.
module irq_responder_chk #(
    parameter int LVL_W = 3,
    parameter int VEC_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  spi_req,
    input logic                  uart_req,
    input logic                  iack_valid,
    input logic [LVL_W-1:0]      iack_level,
    input logic [(2**LVL_W)-1:1] irq_n,
    input logic                  vec_valid,
    input logic [VEC_W-1:0]      vec_out,
    input logic [LVL_W-1:0]      spi_lvl,
    input logic [LVL_W-1:0]      uart_lvl,
    input logic [VEC_W-1:0]      vec_reg
);
    logic [(2**LVL_W)-1:0] active;
    logic spi_on, uart_on, spi_match, uart_match;

    // Helper views: active-high line bank with a dummy level-0 slot
    always_comb begin
        active     = {~irq_n, 1'b0};
        spi_on     = spi_req  && (spi_lvl  != '0);
        uart_on    = uart_req && (uart_lvl != '0);
        spi_match  = iack_valid && spi_on  && (spi_lvl  == iack_level);
        uart_match = iack_valid && uart_on && (uart_lvl == iack_level);
    end

    assert_spi_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_on |=> active[$past(spi_lvl)]);
    assert_uart_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        uart_on |=> active[$past(uart_lvl)]);
    assert_level0_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_on && !uart_on) |=> (&irq_n));
    assert_two_lines_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~irq_n) <= 2);
    assert_ack_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(iack_valid));
    assert_uart_served_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_match && !spi_match) |=> (vec_valid && !vec_out[0]));
    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_out == '0));
    assert_no_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_match && !uart_match) |=> !vec_valid);
    assert_spi_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spi_match |=> (vec_valid && vec_out[0]));
    assert_vector_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_out[VEC_W-1:1] == $past(vec_reg[VEC_W-1:1])));
endmodule

bind irq_responder irq_responder_chk #(
    .LVL_W (LVL_W),
    .VEC_W (VEC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_req    (spi_req),
    .uart_req   (uart_req),
    .iack_valid (iack_valid),
    .iack_level (iack_level),
    .irq_n      (irq_n),
    .vec_valid  (vec_valid),
    .vec_out    (vec_out),
    .spi_lvl    (spi_lvl),
    .uart_lvl   (uart_lvl),
    .vec_reg    (vec_reg)
);

// File: tb/irq_responder_tb.sv
module irq_responder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       spi_req = 1'b0;
    logic       uart_req = 1'b0;
    logic       iack_valid = 1'b0;
    logic [2:0] iack_level = '0;
    logic [7:1] irq_n;
    logic       vec_valid;
    logic [7:0] vec_out;
    logic [3:0] arb_id;

    int total = 0;
    int bad = 0;

    // Bench model of the programmed state
    logic [2:0] m_spi = '0;
    logic [2:0] m_uart = '0;
    logic [7:0] m_vec = 8'h0F;

    always #4 clk = ~clk;   // 125 MHz

    irq_responder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .spi_req(spi_req), .uart_req(uart_req),
        .iack_valid(iack_valid), .iack_level(iack_level), .irq_n(irq_n),
        .vec_valid(vec_valid), .vec_out(vec_out), .arb_id(arb_id)
    );

    function automatic logic [7:1] exp_lines(logic sr, logic ur, logic [2:0] sl, logic [2:0] ul);
        logic [7:1] r = '1;
        if (sr && sl != 0) r[sl] = 1'b0;
        if (ur && ul != 0) r[ul] = 1'b0;
        return r;
    endfunction

    // Returns {valid, vector}
    function automatic logic [8:0] exp_ack(logic iv, logic [2:0] il, logic sr, logic ur,
                                           logic [2:0] sl, logic [2:0] ul, logic [7:0] v);
        if (iv && sr && sl != 0 && sl == il) return {1'b1, v[7:1], 1'b1};
        if (iv && ur && ul != 0 && ul == il) return {1'b1, v[7:1], 1'b0};
        return 9'h000;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, sample after the next negedge
    task automatic step(string req, logic wr, logic addr, logic [7:0] wd,
                        logic sr, logic ur, logic iv, logic [2:0] il);
        logic [7:1] el;
        logic [8:0] ea;
        cfg_wr = wr; cfg_addr = addr; cfg_wdata = wd;
        spi_req = sr; uart_req = ur; iack_valid = iv; iack_level = il;
        el = exp_lines(sr, ur, m_spi, m_uart);
        ea = exp_ack(iv, il, sr, ur, m_spi, m_uart, m_vec);
        if (wr && !addr) begin m_spi = wd[2:0]; m_uart = wd[6:4]; end
        if (wr && addr) m_vec = wd;
        @(posedge clk);
        @(negedge clk);
        check({req, " lines"}, {9'h0, irq_n}, {9'h0, el});
        check({req, " ack"}, {7'h0, vec_valid, vec_out}, {7'h0, ea});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset lines", {9'h0, irq_n}, 16'h007F);
        check("R1 reset strobe", {7'h0, vec_valid, vec_out}, 16'h0);
        // R10: arbitration identity
        check("R10 arb id", {12'h0, arb_id}, 16'h3);
        // R4: requests at reset levels (0) drive nothing, acks unanswered
        step("R4 level0", 1'b0, 1'b0, 8'h0, 1'b1, 1'b1, 1'b1, 3'd0);
        // R2: levels spi=5 uart=2
        step("R2 write levels", 1'b1, 1'b0, 8'h25, 1'b0, 1'b0, 1'b0, 3'd0);
        // R5: both lines low; R3
        step("R5 R3 two lines", 1'b0, 1'b0, 8'h0, 1'b1, 1'b1, 1'b0, 3'd0);
        // R9: reset vector gives 0x0F for SPI
        step("R9 R6 spi ack", 1'b0, 1'b0, 8'h0, 1'b1, 1'b1, 1'b1, 3'd5);
        // R9: 0x0E for UART
        step("R9 R6 uart ack", 1'b0, 1'b0, 8'h0, 1'b1, 1'b1, 1'b1, 3'd2);
        // R6: strobe lasts one cycle
        step("R6 pulse end", 1'b0, 1'b0, 8'h0, 1'b1, 1'b1, 1'b0, 3'd2);
        // R7: mismatched level, and level 0
        step("R7 mismatch", 1'b0, 1'b0, 8'h0, 1'b1, 1'b1, 1'b1, 3'd6);
        step("R7 level0 ack", 1'b0, 1'b0, 8'h0, 1'b1, 1'b1, 1'b1, 3'd0);
        // R7: owner of the level not requesting
        step("R7 idle owner", 1'b0, 1'b0, 8'h0, 1'b0, 1'b1, 1'b1, 3'd5);
        // R2 R9: new vector
        step("R2 write vector", 1'b1, 1'b1, 8'hA4, 1'b0, 1'b0, 1'b0, 3'd0);
        // R8: tie at level 3
        step("R2 tie levels", 1'b1, 1'b0, 8'h33, 1'b0, 1'b0, 1'b0, 3'd0);
        step("R8 tie ack", 1'b0, 1'b0, 8'h0, 1'b1, 1'b1, 1'b1, 3'd3);
        step("R8 uart alone", 1'b0, 1'b0, 8'h0, 1'b0, 1'b1, 1'b1, 3'd3);
        // R4: SPI masked by level 0 while UART at 7
        step("R4 mask write", 1'b1, 1'b0, 8'h70, 1'b0, 1'b0, 1'b0, 3'd0);
        step("R4 spi masked", 1'b0, 1'b0, 8'h0, 1'b1, 1'b0, 1'b1, 3'd0);
        step("R3 line release", 1'b0, 1'b0, 8'h0, 1'b0, 1'b1, 1'b0, 3'd0);
        // Constrained random mix (R3 R5 R6 R7 R8)
        for (int i = 0; i < 600; i++) begin
            logic wr = ($urandom % 8) == 0;
            logic ad = $urandom % 2;
            logic [7:0] wd = 8'($urandom);
            logic iv = ($urandom % 3) == 0;
            logic [2:0] il = ($urandom % 2) ? m_spi : 3'($urandom);
            step("R6 random", wr, ad, wd, 1'($urandom), 1'($urandom), iv, il);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule